// File: doc/BRIEF.md
# Multi-mode program bank mapper

This block translates CPU addresses into addresses of a program ROM that is larger than the CPU can see directly. The upper 32 KB of the CPU space (0x8000-0xFFFF) is split into four 8 KB slots, and bits 14:13 of the CPU address choose the slot. The 8 KB work window at 0x6000-0x7FFF can be served by either external RAM or a ROM bank. Four 7-bit bank registers and a mode register decide which ROM bank each slot shows.

The program mode has three bits. The low two bits choose the arrangement:
- one 32 KB block,
- two 16 KB halves,
- four 8 KB slots,
- four 8 KB slots whose register values are bit-reversed.

The top bit chooses what feeds the highest slot. When it is clear, the highest slot is pinned to the last ROM bank. When it is set, the highest slot is taken from the fourth register.

The CPU writes the registers through a simple write strobe. The read address is registered each cycle into a ROM address, a ROM select and a RAM select.

Top module: `prg_bank_mapper`

## Requirements
- R1: A write with address 0x8000-0x8007 stores data bits 6:0 into bank register (address bits 1:0); data bit 7 is dropped. Writes to other addresses leave the bank registers unchanged.
- R2: A write to 0xD000 or 0xD004 stores data bits 2:0 as the program mode and data bit 7 as the work-window ROM flag. Writes to any other address, for example 0xD001, leave the mode and the flag unchanged.
- R3: In modes 0 and 4, slot s (s = 0..3) maps bank base+s. The base is ROM_BANKS-4 in mode 0 and register 3 in mode 4.
- R4: In modes 1 and 5, slots 0 and 1 map register 1 and register 1 + 1. Slots 2 and 3 map base and base+1, where the base is ROM_BANKS-2 in mode 1 and register 3 in mode 5.
- R5: In modes 2 and 6, slots 0-2 map registers 0-2. Slot 3 maps ROM_BANKS-1 in mode 2 and register 3 in mode 6.
- R6: Modes 3 and 7 behave like modes 2 and 6, except that each register value is first bit-reversed across 7 bits (bit i moves to bit 6-i). The fixed last bank of mode 3 is not reversed.
- R7: A read at 0x6000-0x7FFF with the flag set gives rom_sel=1 and ram_sel=0, using a work bank that depends on mode bits 1:0. The work bank is: 0 gives reg3*4+3, 1 gives reg3*2+1, 2 gives reg3, 3 gives reg3 reversed. With the flag clear the read gives ram_sel=1, rom_sel=0 and rom_addr=0.
- R8: Every bank number, work bank included, is ANDed with ROM_BANKS-1 before use.
- R9: rom_addr is {bank, read address bits 12:0}. The outputs appear one clock after the read address is presented and reflect registers written at or before the previous edge.
- R10: A read address below 0x6000 gives rom_sel=0, ram_sel=0 and rom_addr=0.
- R11: Synchronous reset clears all outputs, all bank registers, the mode and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address |
| rom_addr | output | $clog2(ROM_BANKS)+13 | Registered ROM byte address |
| rom_sel | output | 1 | Registered: read is served by ROM |
| ram_sel | output | 1 | Registered: read is served by work RAM |

## Verification
Directed reads cover several cases:
- the state right after reset, where mode 0 maps the last four banks;
- a register write with data bit 7 set, together with masking;
- the mirrored mode address, and a near-miss mode address that must be ignored;
- a bit-reversed bank number that survives the mask, which tells a reversal from a plain or shifted copy;
- both sources of the work window.

Random writes then mix register, mode and stray addresses, and each is followed by reads spread over all four slots, the work window and low memory. This separates the fixed-last-bank forms from the register-driven forms, the 16 KB from the 8 KB arrangements, and the four work-bank formulas.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int REG_W  = 7;
  localparam int CPU_AW = 16;
  localparam int CPU_DW = 8;
  localparam int OFS_W  = 13;
  localparam int NSLOT  = 4;

  typedef logic [NSLOT-1:0][REG_W-1:0] bank_file_t;

  function automatic logic [REG_W-1:0] mirror_bits(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) r[i] = v[REG_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [CPU_DW-1:0] wr_data,
  output bank_file_t        regs_q,
  output logic [2:0]        mode_q,
  output logic              work_rom_q
);
  logic hit_bank, hit_mode;

  assign hit_bank = wr_en && (wr_addr[CPU_AW-1:3] == 13'h1000);
  assign hit_mode = wr_en && ((wr_addr & 16'hFFFB) == 16'hD000);

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q     <= '0;
      mode_q     <= '0;
      work_rom_q <= 1'b0;
    end else begin
      if (hit_bank) regs_q[wr_addr[1:0]] <= wr_data[REG_W-1:0];
      if (hit_mode) begin
        mode_q     <= wr_data[2:0];
        work_rom_q <= wr_data[7];
      end
    end
  end
endmodule

// File: rtl/prg_slot_calc.sv
module prg_slot_calc
  import prg_map_pkg::*;
#(
  parameter int ROM_BANKS = 16,
  parameter int BANK_W    = $clog2(ROM_BANKS)
) (
  input  bank_file_t                   regs,
  input  logic [2:0]                   mode,
  output logic [NSLOT-1:0][BANK_W-1:0] slot_bank,
  output logic [BANK_W-1:0]            work_bank
);
  localparam int WIDE_W = REG_W + 2;
  localparam logic [WIDE_W-1:0] MASK_W = WIDE_W'(ROM_BANKS - 1);
  localparam logic [WIDE_W-1:0] LAST_W = WIDE_W'(ROM_BANKS - 1);

  logic [WIDE_W-1:0] r3_w;
  assign r3_w = WIDE_W'(regs[3]);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [WIDE_W-1:0] raw;
    logic [WIDE_W-1:0] own_w;
    logic [WIDE_W-1:0] own_rev_w;
    assign own_w     = WIDE_W'(regs[s]);
    assign own_rev_w = WIDE_W'(mirror_bits(regs[s]));

    always_comb begin
      case (mode[1:0])
        2'd0: raw = (mode[2] ? r3_w : (LAST_W - WIDE_W'(3))) + WIDE_W'(s);
        2'd1: begin
          if (s < 2) raw = WIDE_W'(regs[1]) + WIDE_W'(s);
          else       raw = (mode[2] ? r3_w : (LAST_W - WIDE_W'(1))) + WIDE_W'(s - 2);
        end
        2'd2:    raw = (s == 3 && !mode[2]) ? LAST_W : own_w;
        default: raw = (s == 3 && !mode[2]) ? LAST_W : own_rev_w;
      endcase
      slot_bank[s] = BANK_W'(raw & MASK_W);
    end
  end

  logic [WIDE_W-1:0] work_raw;
  always_comb begin
    case (mode[1:0])
      2'd0:    work_raw = {regs[3], 2'b11};
      2'd1:    work_raw = {1'b0, regs[3], 1'b1};
      2'd2:    work_raw = r3_w;
      default: work_raw = WIDE_W'(mirror_bits(regs[3]));
    endcase
    work_bank = BANK_W'(work_raw & MASK_W);
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ROM_BANKS = 16,
  localparam int BANK_W   = $clog2(ROM_BANKS),
  localparam int ROM_AW   = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [CPU_DW-1:0] wr_data,
  input  logic [CPU_AW-1:0] rd_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_sel,
  output logic              ram_sel
);
  bank_file_t                   regs_q;
  logic [2:0]                   prg_mode_q;
  logic                         work_rom_q;
  logic [NSLOT-1:0][BANK_W-1:0] slot_bank;
  logic [BANK_W-1:0]            work_bank;

  prg_bank_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .regs_q     (regs_q),
    .mode_q     (prg_mode_q),
    .work_rom_q (work_rom_q)
  );

  prg_slot_calc #(.ROM_BANKS(ROM_BANKS), .BANK_W(BANK_W)) u_calc (
    .regs      (regs_q),
    .mode      (prg_mode_q),
    .slot_bank (slot_bank),
    .work_bank (work_bank)
  );

  logic [OFS_W-1:0] ofs;
  assign ofs = rd_addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_sel  <= 1'b0;
      ram_sel  <= 1'b0;
    end else if (rd_addr[15]) begin
      rom_addr <= {slot_bank[rd_addr[14:13]], ofs};
      rom_sel  <= 1'b1;
      ram_sel  <= 1'b0;
    end else if (rd_addr[15:13] == 3'b011) begin
      rom_addr <= work_rom_q ? {work_bank, ofs} : '0;
      rom_sel  <= work_rom_q;
      ram_sel  <= !work_rom_q;
    end else begin
      rom_addr <= '0;
      rom_sel  <= 1'b0;
      ram_sel  <= 1'b0;
    end
  end
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int ROM_BANKS = 16,
  parameter int ROM_AW    = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       rd_addr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic [2:0]        prg_mode
);
  localparam int BANK_W = ROM_AW - 13;

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rom_sel && ram_sel)); // R7

  AST_UPPER_IS_ROM: assert property (@(posedge clk) disable iff (rst)
    rd_addr[15] |=> (rom_sel && !ram_sel)); // R9

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    rd_addr[15] |=> (rom_addr[12:0] == $past(rd_addr[12:0]))); // R9

  AST_LOW_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[15:13] < 3'd3) |=> (!rom_sel && !ram_sel && rom_addr == '0)); // R10

  AST_TOP_SLOT_LAST: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[15:13] == 3'b111 && !prg_mode[2])
      |=> (rom_addr[ROM_AW-1:13] == BANK_W'(ROM_BANKS - 1))); // R5
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.ROM_BANKS(ROM_BANKS), .ROM_AW(ROM_AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_addr  (rd_addr),
  .rom_addr (rom_addr),
  .rom_sel  (rom_sel),
  .ram_sel  (ram_sel),
  .prg_mode (prg_mode_q)
);

// File: tb/sim_prg_bank_mapper.sv
module sim_prg_bank_mapper;
  localparam int NB = 16;
  localparam int BW = $clog2(NB);
  localparam int AW = BW + 13;

  logic          clk = 0;
  logic          rst = 1;
  logic          wr_en = 0;
  logic [15:0]   wr_addr = 0;
  logic [7:0]    wr_data = 0;
  logic [15:0]   rd_addr = 0;
  logic [AW-1:0] rom_addr;
  logic          rom_sel, ram_sel;

  int checks = 0;
  int fails  = 0;

  int m_reg [4];
  int m_mode;
  bit m_wrom;

  always #10 clk = ~clk;

  prg_bank_mapper #(.ROM_BANKS(NB)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_sel(ram_sel)
  );

  function automatic int flip7(input int v);
    int o = 0;
    for (int k = 0; k < 7; k++) if (v[k]) o = o | (1 << (6 - k));
    return o;
  endfunction

  // expected {rom_sel, ram_sel, rom_addr}
  function automatic logic [AW+1:0] predict(input logic [15:0] a);
    int b, s, lo;
    s = int'(a[14:13]);
    lo = int'(a[12:0]);
    if (a[15]) begin
      case (m_mode)
        0: b = NB - 4 + s;
        4: b = m_reg[3] + s;
        1: b = (s < 2) ? m_reg[1] + s : NB - 2 + (s - 2);
        5: b = (s < 2) ? m_reg[1] + s : m_reg[3] + (s - 2);
        2: b = (s == 3) ? NB - 1 : m_reg[s];
        6: b = m_reg[s];
        3: b = (s == 3) ? NB - 1 : flip7(m_reg[s]);
        default: b = flip7(m_reg[s]);
      endcase
      b = b & (NB - 1);
      return {1'b1, 1'b0, AW'(b * 8192 + lo)};
    end else if (a[15:13] == 3'b011) begin
      if (!m_wrom) return {1'b0, 1'b1, AW'(0)};
      case (m_mode % 4)
        0: b = m_reg[3] * 4 + 3;
        1: b = m_reg[3] * 2 + 1;
        2: b = m_reg[3];
        default: b = flip7(m_reg[3]);
      endcase
      b = b & (NB - 1);
      return {1'b1, 1'b0, AW'(b * 8192 + lo)};
    end
    return '0;
  endfunction

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a[15:3] == 13'h1000) m_reg[a[1:0]] = int'(d[6:0]);
    if ((a & 16'hFFFB) == 16'hD000) begin
      m_mode = int'(d[2:0]);
      m_wrom = d[7];
    end
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [AW+1:0] exp_v;
    @(negedge clk);
    rd_addr = a;
    exp_v = predict(a);
    @(negedge clk);
    checks++;
    if ({rom_sel, ram_sel, rom_addr} !== exp_v) begin
      fails++;
      $display("FAIL %s rd=%h actual sel=%b%b addr=%h expected sel=%b%b addr=%h",
               tag, a, rom_sel, ram_sel, rom_addr, exp_v[AW+1], exp_v[AW], exp_v[AW-1:0]);
    end
  endtask

  function automatic string tag_of(input logic [15:0] a);
    if (a < 16'h6000) return "R10";
    if (a < 16'h8000) return "R7";
    case (m_mode % 4)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #4ms;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] stray [6];
    int dummy;
    stray = '{16'h8008, 16'h9000, 16'hD001, 16'hD008, 16'h7000, 16'h4000};
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    m_mode = 0; m_wrom = 0;
    dummy = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    rst = 0;

    // R11: reset state
    checks++;
    if (rom_addr !== '0 || rom_sel !== 0 || ram_sel !== 0) begin
      fails++;
      $display("FAIL R11 actual %b%b %h expected 00 0", rom_sel, ram_sel, rom_addr);
    end
    do_read(16'h8000, "R11");
    do_read(16'h6000, "R11");
    // R1 + R8: data bit 7 dropped, bank masked
    do_write(16'h8005, 8'hFF);
    do_write(16'hD000, 8'h02);
    do_read(16'hA123, "R1");
    do_read(16'hFFFF, "R5");
    // R2: mirrored mode address, work ROM flag
    do_write(16'h8003, 8'h05);
    do_write(16'hD004, 8'h86);
    do_read(16'hE010, "R2");
    do_read(16'h6001, "R7");
    // R2: near-miss address ignored
    do_write(16'hD001, 8'h00);
    do_read(16'hE010, "R2");
    // R6: reversal
    do_write(16'h8000, 8'h40);
    do_write(16'hD000, 8'h03);
    do_read(16'h8000, "R6");
    do_read(16'h9FFF, "R9");
    do_read(16'h5FFF, "R10");
    // R7: mode 0 work bank, R8: mask of work bank
    do_write(16'h8003, 8'h01);
    do_write(16'hD000, 8'h80);
    do_read(16'h7000, "R7");
    do_write(16'h8003, 8'h07);
    do_read(16'h7ABC, "R8");

    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 5);
      if (op == 0) do_write(16'h8000 | 16'($urandom % 8), 8'($urandom));
      else if (op == 1) do_write(($urandom % 2) ? 16'hD004 : 16'hD000, 8'($urandom));
      else if (op == 2) do_write(stray[$urandom % 6], 8'($urandom));
      else begin
        logic [15:0] a;
        a = 16'($urandom);
        if (a < 16'h6000 && ($urandom % 4) != 0) a = a | 16'h8000;
        do_read(a, tag_of(a));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule